// File: doc/BRIEF.md
# Byte-Lane Load/Store Alignment Unit

This unit sits between a 32-bit integer datapath and a little-endian data memory that is addressed per byte but read and written a full word at a time. A request carries a byte address, an access size (one, two or four bytes), a direction and, for stores, the data. The unit drops the low address bits to form the memory word address. It copies the store data into every lane and enables only the lanes the access covers. A request whose address is not a whole multiple of its size is refused and flagged in the same cycle, and nothing reaches memory.

Loads are split over two cycles. In the cycle after an accepted load, the memory presents the addressed word. The unit then selects the addressed byte or half-word, which is lowest-addressed byte in the least significant position, and widens it to 32 bits. It widens by copying the sign bit or by filling with zeros, as the request asked. Because the held load context is separate from the request path, a new request can be accepted in the same cycle that an earlier load's data is being extracted.

Top module: `lsa_unit`

## Requirements
- R1: For an accepted request, `mem_addr` equals `req_addr` with bits 1:0 forced to zero.
- R2: Size encoding on `req_size`: 0 = byte, 1 = half-word, 2 = word, 3 = reserved. A valid request is misaligned when it is a half-word with address bit 0 set, a word with either of address bits 1:0 set, or it uses the reserved size. A byte access is never misaligned.
- R3: A misaligned valid request raises `addr_err` in that same cycle only. It holds `mem_req` low and `mem_be` at zero, and it produces no load result in the next cycle.
- R4: A byte store drives `req_wdata[7:0]` into all four lanes of `mem_wdata`. It sets exactly one bit of `mem_be`, at position `req_addr[1:0]`.
- R5: A half-word store drives `req_wdata[15:0]` into both halves of `mem_wdata`. It sets `mem_be` to 4'b0011 for address bit 1 clear, or 4'b1100 for address bit 1 set.
- R6: A word store passes `req_wdata` unchanged to `mem_wdata` and sets `mem_be` to 4'b1111.
- R7: An accepted load raises `mem_req` with `mem_we` low, and `mem_be` shows the lanes it covers as in R4 to R6. `ld_valid` is high for exactly the next cycle, and `ld_data` in that cycle is derived from `mem_rdata` of that cycle.
- R8: A byte load returns lane `req_addr[1:0]` of the word (lane k is `mem_rdata[8k+7:8k]`) in `ld_data[7:0]`. Bits 31:8 copy bit 7 when `req_signed` is 1 and are zero when it is 0.
- R9: A half-word load returns `mem_rdata[15:0]` (address bit 1 clear) or `mem_rdata[31:16]` (set) in `ld_data[15:0]`. Bits 31:16 are sign- or zero-filled per `req_signed`.
- R10: A word load returns `mem_rdata` unchanged, whatever `req_signed` is.
- R11: With `req_valid` low, `mem_req`, `addr_err` and every bit of `mem_be` are low.
- R12: While `rst_n` is low, `ld_valid` is low, and a load presented during reset yields no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Access size code (R2) |
| req_signed | input | 1 | Load widening: 1 = sign, 0 = zero |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data, right-aligned |
| mem_rdata | input | 32 | Word returned for the load of the previous cycle |
| mem_req | output | 1 | Memory access issued |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_be | output | 4 | Per-lane byte enables |
| mem_wdata | output | 32 | Lane-replicated write data |
| addr_err | output | 1 | Misaligned request refused |
| ld_valid | output | 1 | Load result present |
| ld_data | output | 32 | Extended load result |

## Verification
The extraction of a load's data and the lane formation for a new request can happen in the same cycle. The first uses the held context, and the second uses the live request. Every swept load, both legal and refused, is followed directly by a byte store to a rotating lane. This store arrives while the memory word for the load is on `mem_rdata`. In that one cycle the bench compares the load result against a value computed by shifting and masking, and it compares the store's enables and data against lane arithmetic. A mix-up between the held and the live offset or size therefore appears in one output or the other.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

   typedef enum logic [1:0] {
      ACC_BYTE = 2'd0,
      ACC_HALF = 2'd1,
      ACC_WORD = 2'd2,
      ACC_RSVD = 2'd3
   } acc_size_e;

   // Context held from a load request until its data returns.
   typedef struct packed {
      logic      sext;
      acc_size_e size;
      logic [2:0] lane;
   } ld_ctx_t;

endpackage

// File: rtl/lsa_align_check.sv
module lsa_align_check
   import lsa_pkg::*;
#(
   parameter int OFF_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             valid,
   input  acc_size_e        size,
   input  logic [OFF_W-1:0] off,
   output logic             bad
);

   initial assert (OFF_W >= 2) else $error("lsa_align_check: OFF_W must be at least 2");

   always_comb begin
      unique case (size)
         ACC_BYTE: bad = 1'b0;
         ACC_HALF: bad = off[0];
         ACC_WORD: bad = |off[1:0];
         default:  bad = 1'b1;
      endcase
   end

   // Reserved size code never passes, whatever the address.
   assert_rsvd_refused_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && size == ACC_RSVD) |-> bad);

   // Byte accesses are legal at every offset.
   assert_byte_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && size == ACC_BYTE) |-> !bad);

endmodule

// File: rtl/lsa_store_lane.sv
module lsa_store_lane
   import lsa_pkg::*;
#(
   parameter  int DATA_W = 32,
   parameter  int REG_W  = 32,
   localparam int LANES  = DATA_W / 8,
   localparam int OFF_W  = $clog2(LANES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  acc_size_e         size,
   input  logic [OFF_W-1:0]  off,
   input  logic [REG_W-1:0]  src,
   output logic [LANES-1:0]  be,
   output logic [DATA_W-1:0] wdata
);

   initial assert (REG_W == 32) else $error("lsa_store_lane: REG_W must be 32");

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [7:0] lane_byte;
      logic       lane_hit;

      always_comb begin
         unique case (size)
            ACC_BYTE: lane_byte = src[7:0];
            ACC_HALF: lane_byte = src[(l % 2) * 8 +: 8];
            default:  lane_byte = src[(l % 4) * 8 +: 8];
         endcase
         // Lane belongs to the access when its group index matches the offset's.
         lane_hit = ((l >> int'(size)) == (int'(off) >> int'(size)));
      end

      assign wdata[l*8 +: 8] = lane_byte;
      assign be[l]           = en && lane_hit;
   end

   assert_byte_single_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (en && size == ACC_BYTE) |-> $countones(be) == 1);

   assert_half_two_lanes_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (en && size == ACC_HALF) |-> $countones(be) == 2);

   assert_word_four_lanes_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (en && size == ACC_WORD) |-> $countones(be) == 4);

   assert_quiet_when_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> be == '0);

endmodule

// File: rtl/lsa_load_extract.sv
module lsa_load_extract
   import lsa_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int REG_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid,
   input  ld_ctx_t           ctx,
   input  logic [DATA_W-1:0] rdata,
   output logic [REG_W-1:0]  data
);

   initial assert (REG_W == 32 && DATA_W >= REG_W)
      else $error("lsa_load_extract: unsupported widths");

   logic [DATA_W-1:0] shifted;
   logic              fill;

   assign shifted = rdata >> {ctx.lane, 3'b000};

   always_comb begin
      unique case (ctx.size)
         ACC_BYTE: begin
            fill = ctx.sext & shifted[7];
            data = {{(REG_W-8){fill}}, shifted[7:0]};
         end
         ACC_HALF: begin
            fill = ctx.sext & shifted[15];
            data = {{(REG_W-16){fill}}, shifted[15:0]};
         end
         default: begin
            fill = 1'b0;
            data = shifted[REG_W-1:0];
         end
      endcase
   end

   assert_byte_zext_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !ctx.sext && ctx.size == ACC_BYTE) |-> data[REG_W-1:8] == '0);

   assert_half_sext_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && ctx.sext && ctx.size == ACC_HALF) |->
         ($countones(data[REG_W-1:15]) == 0 || $countones(data[REG_W-1:15]) == REG_W - 15));

endmodule

// File: rtl/lsa_unit.sv
module lsa_unit
   import lsa_pkg::*;
#(
   parameter  int ADDR_W = 32,
   parameter  int DATA_W = 32,
   localparam int REG_W  = 32,
   localparam int LANES  = DATA_W / 8,
   localparam int OFF_W  = $clog2(LANES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [1:0]        req_size,
   input  logic              req_signed,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [REG_W-1:0]  req_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [LANES-1:0]  mem_be,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              addr_err,
   output logic              ld_valid,
   output logic [REG_W-1:0]  ld_data
);

   initial assert (DATA_W == 32 || DATA_W == 64)
      else $error("lsa_unit: DATA_W must be 32 or 64");
   initial assert (ADDR_W > OFF_W)
      else $error("lsa_unit: ADDR_W too small");

   acc_size_e        size_in;
   logic [OFF_W-1:0] off_in;
   logic             misaligned;
   ld_ctx_t          ctx_q;
   logic             ld_valid_q;

   assign size_in = acc_size_e'(req_size);
   assign off_in  = req_addr[OFF_W-1:0];

   lsa_align_check #(.OFF_W(OFF_W)) u_align (
      .clk   (clk),
      .rst_n (rst_n),
      .valid (req_valid),
      .size  (size_in),
      .off   (off_in),
      .bad   (misaligned)
   );

   assign addr_err = req_valid & misaligned;
   assign mem_req  = req_valid & ~misaligned;
   assign mem_we   = mem_req & req_write;
   assign mem_addr = {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

   lsa_store_lane #(.DATA_W(DATA_W), .REG_W(REG_W)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (mem_req),
      .size  (size_in),
      .off   (off_in),
      .src   (req_wdata),
      .be    (mem_be),
      .wdata (mem_wdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ld_valid_q <= 1'b0;
         ctx_q      <= '0;
      end else begin
         ld_valid_q <= mem_req & ~req_write;
         if (mem_req && !req_write) begin
            ctx_q.sext <= req_signed;
            ctx_q.size <= size_in;
            ctx_q.lane <= 3'(off_in);
         end
      end
   end

   assign ld_valid = ld_valid_q;

   lsa_load_extract #(.DATA_W(DATA_W), .REG_W(REG_W)) u_extract (
      .clk   (clk),
      .rst_n (rst_n),
      .valid (ld_valid_q),
      .ctx   (ctx_q),
      .rdata (mem_rdata),
      .data  (ld_data)
   );

   assert_refused_no_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
      addr_err |-> (!mem_req && mem_be == '0));

   assert_refused_no_result_R3: assert property (@(posedge clk) disable iff (!rst_n)
      addr_err |=> !ld_valid);

   assert_half_odd_refused_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_size == 2'd1 && req_addr[0]) |-> addr_err);

   assert_result_follows_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we) |=> ld_valid);

   assert_store_no_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_req || mem_we) |=> !ld_valid);

   assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> (!mem_req && !addr_err));

endmodule

// File: tb/lsa_unit_bench.sv
`timescale 1ns/1ps
module lsa_unit_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [1:0]  req_size = 2'd0;
   logic        req_signed = 1'b0;
   logic [31:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic [31:0] mem_rdata = '0;
   logic        mem_req, mem_we, addr_err, ld_valid;
   logic [31:0] mem_addr, mem_wdata, ld_data;
   logic [3:0]  mem_be;

   int tests = 0;
   int failed = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   lsa_unit u_lsa_unit (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
      .req_signed(req_signed), .req_addr(req_addr), .req_wdata(req_wdata),
      .mem_rdata(mem_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
      .mem_wdata(mem_wdata), .addr_err(addr_err), .ld_valid(ld_valid), .ld_data(ld_data)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         failed++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic bit exp_err(input int sz, input int off);
      return (sz == 3) || (sz == 1 && (off % 2) != 0) || (sz == 2 && off != 0);
   endfunction

   function automatic logic [3:0] exp_be(input int sz, input int off);
      logic [3:0] r = '0;
      int nb = 1 << sz;
      if (exp_err(sz, off)) return r;
      for (int l = 0; l < 4; l++) if (l >= off && l < off + nb) r[l] = 1'b1;
      return r;
   endfunction

   function automatic logic [31:0] exp_wd(input int sz, input logic [31:0] wd);
      logic [31:0] r;
      int nb = 1 << sz;
      for (int l = 0; l < 4; l++) r[l*8 +: 8] = wd[(l % nb) * 8 +: 8];
      return r;
   endfunction

   function automatic logic [31:0] exp_ld(input int sz, input int off, input bit sg,
                                          input logic [31:0] w);
      logic [31:0] v = w >> (off * 8);
      if (sz == 0) return sg ? {{24{v[7]}}, v[7:0]} : {24'h0, v[7:0]};
      if (sz == 1) return sg ? {{16{v[15]}}, v[15:0]} : {16'h0, v[15:0]};
      return w;
   endfunction

   function automatic logic [31:0] pattern(input int p, input int idx);
      case (p)
         0: return 32'h807F_FF01;
         1: return 32'h7F80_01FF;
         2: return 32'h8000_7FFF;
         default: return 32'h5AC3_9E24 ^ (idx * 32'h0101_0101);
      endcase
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failed++;
         tests++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, failed);
         $finish;
      end
   end

   initial begin
      int idx = 0;
      // Reset state, including a load offered during reset (R12, R11).
      @(negedge clk);
      #1;
      chk("R12 ld_valid in reset", {31'h0, ld_valid}, 32'h0);
      chk("R11 mem_req idle", {31'h0, mem_req}, 32'h0);
      chk("R11 mem_be idle", {28'h0, mem_be}, 32'h0);
      chk("R11 addr_err idle", {31'h0, addr_err}, 32'h0);
      req_valid = 1'b1; req_write = 1'b0; req_size = 2'd2; req_addr = 32'h40;
      @(negedge clk);
      #1;
      chk("R12 no result for load in reset", {31'h0, ld_valid}, 32'h0);
      req_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;

      for (int w = 0; w < 2; w++)
      for (int sz = 0; sz < 4; sz++)
      for (int off = 0; off < 4; off++)
      for (int sg = 0; sg < 2; sg++)
      for (int p = 0; p < 4; p++) begin
         logic [31:0] base, wd, rd, cd;
         bit err;
         string sreq;
         idx++;
         err  = exp_err(sz, off);
         base = 32'h1000_0000 + idx * 32'h0001_0104;
         wd   = pattern((p + 1) % 4, idx + 7);
         rd   = pattern(p, idx);
         cd   = 32'hC3A5_0000 | idx;
         sreq = (w == 0) ? "R7" : (sz == 0) ? "R4" : (sz == 1) ? "R5" : "R6";

         // Cycle A: the swept request.
         @(negedge clk);
         req_valid = 1'b1; req_write = w[0]; req_size = sz[1:0]; req_signed = sg[0];
         req_addr = {base[31:2], off[1:0]}; req_wdata = wd;
         #1;
         chk(err ? "R3 addr_err raised" : "R2 addr_err clear", {31'h0, addr_err}, {31'h0, err});
         chk("R3 mem_req", {31'h0, mem_req}, {31'h0, !err});
         chk(err ? "R3 mem_be" : sreq, {28'h0, mem_be}, {28'h0, exp_be(sz, off)});
         chk("R7 no stale result", {31'h0, ld_valid}, 32'h0);
         if (!err) begin
            chk("R1 mem_addr", mem_addr, {base[31:2], 2'b00});
            chk("R7 mem_we", {31'h0, mem_we}, {31'h0, w[0]});
            if (w == 1) chk(sreq, mem_wdata, exp_wd(sz, wd));
         end

         // Cycle B: load data returns while a byte store is requested.
         @(negedge clk);
         mem_rdata = rd;
         req_write = 1'b1; req_size = 2'd0; req_signed = 1'b0;
         req_addr = {base[31:2] ^ 30'h155, idx[1:0]}; req_wdata = cd;
         #1;
         if (w == 0 && !err) begin
            chk("R7 ld_valid", {31'h0, ld_valid}, 32'h1);
            chk((sz == 0) ? "R8 ld_data" : (sz == 1) ? "R9 ld_data" : "R10 ld_data",
                ld_data, exp_ld(sz, off, sg[0], rd));
         end else begin
            chk(err ? "R3 no result" : "R7 store no result", {31'h0, ld_valid}, 32'h0);
         end
         chk("R4 overlap mem_be", {28'h0, mem_be}, {28'h0, exp_be(0, idx % 4)});
         chk("R4 overlap mem_wdata", mem_wdata, {4{cd[7:0]}});
         chk("R2 overlap addr_err", {31'h0, addr_err}, 32'h0);
      end

      @(negedge clk);
      req_valid = 1'b0; req_size = 2'd3; req_addr = 32'h3;
      #1;
      chk("R11 mem_req idle", {31'h0, mem_req}, 32'h0);
      chk("R11 mem_be idle", {28'h0, mem_be}, 32'h0);
      chk("R11 addr_err idle", {31'h0, addr_err}, 32'h0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, failed);
      $finish;
   end

endmodule